// File: doc/BRIEF.md
# Three-Channel Pulse Window Discriminator

This block receives the digitized outputs of six analog comparators, a lower-level and an upper-level comparator for each of three channels, together with an inhibit line. For every channel it follows each pulse from the moment the lower-level comparator goes high until it goes low again. It accepts the pulse only if the upper-level comparator stayed low for that whole interval, which means the pulse peaked inside that channel's energy window. Each accepted pulse produces a single-cycle strobe on that channel's output bit.

The inhibit line is held high while a preamplifier recovers from a reset. While it is high, no channel can produce a strobe. Any pulse that overlaps the inhibit, even for part of its length, is thrown away. Every asynchronous input passes through a two-stage synchronizer before the logic uses it. The reset is asserted asynchronously and released synchronously inside the block.

Top module: `tri_window_disc`

## Requirements
- R1: After reset, all three strobe outputs are low.
- R2: A pulse is accepted when the lower-level input goes high and later goes low, and the upper-level input stays low for that whole time. The strobe rises on the third rising clock edge after the lower-level input falls, and it stays high for exactly one clock cycle.
- R3: A pulse is rejected, with no strobe, if the upper-level input is high at any sampled point while the lower-level input is high, including a single brief excursion in the middle of the pulse.
- R4: An upper-level input that is high only while the lower-level input is low has no effect on the next pulse.
- R5: A pulse that is in progress when inhibit goes high is discarded, even if inhibit returns low before the lower-level input falls.
- R6: A pulse whose lower-level input rises while inhibit is high is discarded.
- R7: The channels are independent. Bit n of each comparator bus and of the strobe output belongs to channel n (n = 0..2), and simultaneous pulses on different channels are each judged on their own inputs.
- R8: A rejection affects only the pulse in which it happened. The next clean pulse on the same channel is accepted.
- R9: A strobe is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lower_cmp_i | input | 3 | Lower-level comparator outputs, high while the pulse is above the lower level |
| upper_cmp_i | input | 3 | Upper-level comparator outputs, high while the pulse is above the upper level |
| inhibit_i | input | 1 | Active-high blanking during preamplifier reset recovery |
| strobe_o | output | 3 | One-cycle accepted-pulse strobes, one bit per channel |

## Verification
The hardest case to reach from the ports is a pulse that becomes tainted and then looks clean again before it ends. Examples are an upper-level blip that returns low mid-pulse, and an inhibit window that opens and closes entirely inside a long lower-level interval. The stimulus holds the lower-level input high for many cycles and places the short upper-level or inhibit excursion well away from both of its edges, so the synchronizer delay cannot hide it. It then confirms that no strobe appears and that the following clean pulse is accepted again. The bench also checks that a strobe lands on exactly the expected clock, so that any change in the latency of the synchronizer or the decision register is caught.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_LIVE = 2'd1,
    CH_VETO = 2'd2
  } ch_state_e;
endpackage

// File: rtl/tw_rst_sync.sv
module tw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/tw_sync_bank.sv
module tw_sync_bank #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/tw_chan_tracker.sv
module tw_chan_tracker
  import tw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lower_s,
  input  logic upper_s,
  input  logic inhibit_s,
  output logic strobe_o
);
  ch_state_e state_q, state_d;
  logic      strobe_q, strobe_d;

  always_comb begin
    state_d  = state_q;
    strobe_d = 1'b0;
    unique case (state_q)
      CH_IDLE: begin
        if (lower_s) state_d = (upper_s || inhibit_s) ? CH_VETO : CH_LIVE;
      end
      CH_LIVE: begin
        if (!lower_s) begin
          state_d  = CH_IDLE;
          strobe_d = !(upper_s || inhibit_s);
        end else if (upper_s || inhibit_s) begin
          state_d = CH_VETO;
        end
      end
      CH_VETO: begin
        if (!lower_s) state_d = CH_IDLE;
      end
      default: state_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= CH_IDLE;
      strobe_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      strobe_q <= strobe_d;
    end
  end

  assign strobe_o = strobe_q;

  // R2
  strobe_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> (!$past(lower_s) && $past(lower_s, 2)));

  // R3
  no_strobe_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> !$past(upper_s));

  // R5
  no_strobe_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inhibit_s) |-> !strobe_q);

  // R8
  veto_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CH_VETO && lower_s) |=> (state_q == CH_VETO));

  // R9
  single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);
endmodule

// File: rtl/tri_window_disc.sv
module tri_window_disc #(
  parameter int unsigned N_CH        = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] lower_cmp_i,
  input  logic [N_CH-1:0] upper_cmp_i,
  input  logic            inhibit_i,
  output logic [N_CH-1:0] strobe_o
);
  localparam int unsigned SYNC_W = 2 * N_CH + 1;

  logic              srst_n;
  logic [SYNC_W-1:0] raw_bus;
  logic [SYNC_W-1:0] sync_bus;
  logic [N_CH-1:0]   lower_s;
  logic [N_CH-1:0]   upper_s;
  logic              inhibit_s;

  tw_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign raw_bus = {inhibit_i, upper_cmp_i, lower_cmp_i};

  tw_sync_bank #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .din   (raw_bus),
    .dout  (sync_bus)
  );

  assign lower_s   = sync_bus[N_CH-1:0];
  assign upper_s   = sync_bus[2*N_CH-1:N_CH];
  assign inhibit_s = sync_bus[SYNC_W-1];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    tw_chan_tracker u_trk (
      .clk       (clk),
      .rst_n     (srst_n),
      .lower_s   (lower_s[c]),
      .upper_s   (upper_s[c]),
      .inhibit_s (inhibit_s),
      .strobe_o  (strobe_o[c])
    );
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !srst_n |-> (strobe_o == '0));
endmodule

// File: tb/tb_tri_window_disc.sv
module tb_tri_window_disc;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] lower_cmp_i;
  logic [2:0] upper_cmp_i;
  logic       inhibit_i;
  logic [2:0] strobe_o;

  int n_cmp = 0;
  int n_bad = 0;
  int hits [3];
  logic done = 1'b0;

  always #10 clk = ~clk;

  tri_window_disc dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .lower_cmp_i (lower_cmp_i),
    .upper_cmp_i (upper_cmp_i),
    .inhibit_i   (inhibit_i),
    .strobe_o    (strobe_o)
  );

  always @(negedge clk) begin
    if (rst_n) for (int c = 0; c < 3; c++) if (strobe_o[c]) hits[c]++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_hits();
    for (int c = 0; c < 3; c++) hits[c] = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; lower_cmp_i = '0; upper_cmp_i = '0; inhibit_i = 1'b0;
    idle(3);
    check("R1 strobe during reset", strobe_o, 0);
    rst_n = 1'b1;
    idle(6);
    check("R1 strobe after reset", strobe_o, 0);
  endtask

  // R2: exact latency and width
  task automatic t_accept_timing();
    clear_hits();
    lower_cmp_i[0] = 1'b1;
    idle(8);
    lower_cmp_i[0] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R2 no strobe before third edge", strobe_o[0], 0);
    @(negedge clk);
    check("R2 strobe at third edge", strobe_o[0], 1);
    @(negedge clk);
    check("R2 strobe lasts one cycle", strobe_o[0], 0);
    idle(4);
    check("R2 single strobe count", hits[0], 1);
    check("R9 no extra strobe", hits[1] + hits[2], 0);
  endtask

  // R3: mid-pulse upper blip
  task automatic t_upper_blip();
    clear_hits();
    lower_cmp_i[1] = 1'b1;
    idle(6);
    upper_cmp_i[1] = 1'b1;
    idle(1);
    upper_cmp_i[1] = 1'b0;
    idle(6);
    lower_cmp_i[1] = 1'b0;
    idle(6);
    check("R3 blip rejects pulse", hits[1], 0);
    // R8: next clean pulse accepted
    lower_cmp_i[1] = 1'b1;
    idle(5);
    lower_cmp_i[1] = 1'b0;
    idle(6);
    check("R8 clean pulse after reject", hits[1], 1);
  endtask

  // R4: upper high only while lower low
  task automatic t_upper_outside();
    clear_hits();
    upper_cmp_i[2] = 1'b1;
    idle(5);
    upper_cmp_i[2] = 1'b0;
    idle(3);
    lower_cmp_i[2] = 1'b1;
    idle(5);
    lower_cmp_i[2] = 1'b0;
    idle(6);
    check("R4 upper outside pulse ignored", hits[2], 1);
  endtask

  // R5: inhibit opens and closes inside a pulse
  task automatic t_inhibit_mid();
    clear_hits();
    lower_cmp_i = 3'b111;
    idle(5);
    inhibit_i = 1'b1;
    idle(3);
    inhibit_i = 1'b0;
    idle(6);
    lower_cmp_i = 3'b000;
    idle(6);
    check("R5 inhibit mid-pulse ch0", hits[0], 0);
    check("R5 inhibit mid-pulse ch1", hits[1], 0);
    check("R5 inhibit mid-pulse ch2", hits[2], 0);
  endtask

  // R6: pulse starts under inhibit
  task automatic t_inhibit_start();
    clear_hits();
    inhibit_i = 1'b1;
    idle(4);
    lower_cmp_i[0] = 1'b1;
    idle(3);
    inhibit_i = 1'b0;
    idle(5);
    lower_cmp_i[0] = 1'b0;
    idle(6);
    check("R6 pulse begun under inhibit", hits[0], 0);
  endtask

  // R7: simultaneous independent verdicts
  task automatic t_independent();
    clear_hits();
    lower_cmp_i = 3'b111;
    idle(4);
    upper_cmp_i = 3'b010;
    idle(2);
    upper_cmp_i = 3'b000;
    idle(3);
    lower_cmp_i = 3'b000;
    idle(6);
    check("R7 ch0 accepted", hits[0], 1);
    check("R7 ch1 rejected", hits[1], 0);
    check("R7 ch2 accepted", hits[2], 1);
  endtask

  initial begin
    t_reset();
    t_accept_timing();
    t_upper_blip();
    t_upper_outside();
    t_inhibit_mid();
    t_inhibit_start();
    t_independent();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule